// File: doc/BRIEF.md
# Word/Doubleword Shift Stage with Lost-Bit Carry

This block is a purely combinational shift stage for a 64-bit execution pipe. A three-bit operation code picks one of three operations: a logical shift toward the most significant end, a right shift that is logical or arithmetic according to a signed flag, and an operation that sign-extends the low word of the source and then shifts it left. A mode flag picks word (32-bit) or doubleword (64-bit) behaviour. The stage produces a 64-bit result, a result-valid flag, and a two-bit carry. The carry is set only by an arithmetic right shift of a negative value that drops one or more one-bits.

The operation code, both flags and a tag are presented unchanged on the output side, so the result leaves with the context that came with it. The block holds no state. The pipeline registers on either side belong to the surrounding unit. All operand preparation, the barrel shift and the lost-bit detection settle within one combinational pass.

Top module: `shf_unit`

## Requirements
- R1: Operation code 0 is a left shift. In doubleword mode the amount is bits 6:0 of the amount input, so an amount of 64 to 127 gives a result of zero and bits 63:7 are ignored.
- R2: A left shift in word mode uses amount bits 5:0. The result's bits 31:0 are the low 32 bits of the source shifted left, and bits 63:32 are zero.
- R3: Operation code 1 is a right shift. In doubleword mode the amount is bits 6:0, and the vacated bits are copies of source bit 63 when the signed flag is 1 and zeros when it is 0. An amount of 64 or more gives all sign copies or all zeros.
- R4: A right shift in word mode takes source bits 31:0 and extends them to 64 bits, with sign when the signed flag is 1 and with zeros when it is 0. It shifts the extended value right by amount bits 5:0 and keeps all 64 result bits, so an amount of 32 or more gives all copies of bit 31 or all zeros.
- R5: Operation code 2 sign-extends source bits 31:0 to 64 bits and shifts the value left by amount bits 5:0, keeping 64 bits. The word-mode flag and the signed flag have no effect on it.
- R6: For a right shift with the signed flag set, the carry is 1 exactly when the extended operand is negative and at least one one-bit is shifted out.
- R7: The carry is 0 for left shifts, for code 2 and for logical right shifts. Both carry bits always carry the same value.
- R8: Codes 0, 1 and 2 set the valid flag to 1. Codes 3 to 7 set valid to 0 and force the result and the carry to zero.
- R9: The operation code, the word-mode flag, the signed flag and the tag appear unchanged on their outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code (0 left, 1 right, 2 sign-extend word then left) |
| w32_i | input | 1 | Word (32-bit) mode when 1 |
| sgn_i | input | 1 | Signed (arithmetic) right shift when 1 |
| tag_i | input | TAG_W | Tag carried alongside the operation |
| src_i | input | DW | Source operand |
| amt_i | input | DW | Shift amount register |
| res_o | output | DW | Shift result |
| res_ok_o | output | 1 | Result valid |
| ca_o | output | 2 | Carry, doubleword copy in bit 0 and word copy in bit 1 |
| op_o | output | 3 | Operation code passed through |
| w32_o | output | 1 | Word-mode flag passed through |
| sgn_o | output | 1 | Signed flag passed through |
| tag_o | output | TAG_W | Tag passed through |

## Verification
The hardest case to reach is the carry boundary: a negative operand whose bits below the shift amount are all zero except, possibly, one bit at the very edge of the shifted-out field. Uniform random data almost always has a one-bit somewhere in that field, so it nearly always yields carry 1. The stimulus therefore includes directed operands whose low bits are cleared to exactly the shift amount, and operands one bit past it. Random vectors mix sign-heavy sources and amounts concentrated around 31, 32, 63 and 64 with fully random amounts.

// File: rtl/shf_pkg.sv
package shf_pkg;
    typedef enum logic [2:0] {
        SOP_SHL  = 3'd0,
        SOP_SHR  = 3'd1,
        SOP_SXSL = 3'd2
    } shf_op_e;
endpackage

// File: rtl/shf_prep.sv
// Operand and amount selection for the shift stage.
module shf_prep #(
    parameter int DW = 64,
    parameter int AW = 7
) (
    input  logic [2:0]    op,
    input  logic          w32,
    input  logic          sgn,
    input  logic [DW-1:0] src,
    input  logic [AW-1:0] amt,
    output logic [DW-1:0] opnd,
    output logic [AW-1:0] sh,
    output logic          left,
    output logic          fill,
    output logic          arith,
    output logic          clr_hi,
    output logic          ok
);
    import shf_pkg::*;
    localparam int HW = DW / 2;

    logic [DW-1:0] sx_word;
    logic [DW-1:0] zx_word;
    logic [AW-1:0] sh_word;

    assign sx_word = {{HW{src[HW-1]}}, src[HW-1:0]};
    assign zx_word = {{HW{1'b0}}, src[HW-1:0]};
    assign sh_word = {1'b0, amt[AW-2:0]};

    always_comb begin
        opnd   = '0;
        sh     = '0;
        left   = 1'b0;
        fill   = 1'b0;
        arith  = 1'b0;
        clr_hi = 1'b0;
        ok     = 1'b1;
        unique case (shf_op_e'(op))
            SOP_SHL: begin
                opnd   = src;
                sh     = w32 ? sh_word : amt;
                left   = 1'b1;
                clr_hi = w32;
            end
            SOP_SHR: begin
                opnd  = w32 ? (sgn ? sx_word : zx_word) : src;
                sh    = w32 ? sh_word : amt;
                arith = sgn;
                fill  = sgn & opnd[DW-1];
            end
            SOP_SXSL: begin
                opnd = sx_word;
                sh   = sh_word;
                left = 1'b1;
            end
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/shf_barrel.sv
// Logarithmic right shifter; left shifts go through bit reversal.
module shf_barrel #(
    parameter int DW = 64,
    parameter int AW = 7
) (
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] sh,
    input  logic          left,
    input  logic          fill,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] rev_in;
    logic [DW-1:0] rev_out;
    logic [DW-1:0] stg [AW+1];

    for (genvar i = 0; i < DW; i++) begin : g_rev
        assign rev_in[i]  = din[DW-1-i];
        assign rev_out[i] = stg[AW][DW-1-i];
    end

    assign stg[0] = left ? rev_in : din;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int STRIDE = 1 << k;
        if (STRIDE >= DW) begin : g_all
            assign stg[k+1] = sh[k] ? {DW{fill}} : stg[k];
        end else begin : g_part
            assign stg[k+1] = sh[k] ? {{STRIDE{fill}}, stg[k][DW-1:STRIDE]}
                                    : stg[k];
        end
    end

    assign dout = left ? rev_out : stg[AW];
endmodule

// File: rtl/shf_lost.sv
// Detects one-bits dropped by an arithmetic right shift of a negative value.
module shf_lost #(
    parameter int DW = 64,
    parameter int AW = 7
) (
    input  logic [DW-1:0] opnd,
    input  logic [AW-1:0] sh,
    input  logic          arith,
    output logic          lost
);
    logic [DW-1:0] out_mask;

    for (genvar i = 0; i < DW; i++) begin : g_mask
        assign out_mask[i] = (AW'(i) < sh);
    end

    assign lost = arith & opnd[DW-1] & (|(opnd & out_mask));
endmodule

// File: rtl/shf_unit.sv
module shf_unit #(
    parameter int DW    = 64,
    parameter int TAG_W = 4
) (
    input  logic [2:0]       op_i,
    input  logic             w32_i,
    input  logic             sgn_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic [DW-1:0]    src_i,
    input  logic [DW-1:0]    amt_i,
    output logic [DW-1:0]    res_o,
    output logic             res_ok_o,
    output logic [1:0]       ca_o,
    output logic [2:0]       op_o,
    output logic             w32_o,
    output logic             sgn_o,
    output logic [TAG_W-1:0] tag_o
);
    localparam int AW = $clog2(DW) + 1;
    localparam int HW = DW / 2;

    logic [DW-1:0] opnd;
    logic [AW-1:0] sh;
    logic          left;
    logic          fill;
    logic          arith;
    logic          clr_hi;
    logic          ok;
    logic [DW-1:0] shifted;
    logic          lost;
    logic          amt_hi_unused;

    assign amt_hi_unused = ^amt_i[DW-1:AW];

    shf_prep #(.DW(DW), .AW(AW)) u_prep (
        .op(op_i), .w32(w32_i), .sgn(sgn_i), .src(src_i), .amt(amt_i[AW-1:0]),
        .opnd(opnd), .sh(sh), .left(left), .fill(fill), .arith(arith),
        .clr_hi(clr_hi), .ok(ok)
    );

    shf_barrel #(.DW(DW), .AW(AW)) u_barrel (
        .din(opnd), .sh(sh), .left(left), .fill(fill), .dout(shifted)
    );

    shf_lost #(.DW(DW), .AW(AW)) u_lost (
        .opnd(opnd), .sh(sh), .arith(arith), .lost(lost)
    );

    always_comb begin
        if (!ok)
            res_o = '0;
        else if (clr_hi)
            res_o = {{HW{1'b0}}, shifted[HW-1:0]};
        else
            res_o = shifted;
    end

    assign res_ok_o = ok;
    assign ca_o     = {2{lost & ok}};
    assign op_o     = op_i;
    assign w32_o    = w32_i;
    assign sgn_o    = sgn_i;
    assign tag_o    = tag_i;
endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
    parameter int DW    = 64,
    parameter int TAG_W = 4
) (
    input logic [2:0]       op_i,
    input logic             w32_i,
    input logic             sgn_i,
    input logic [TAG_W-1:0] tag_i,
    input logic [DW-1:0]    src_i,
    input logic [DW-1:0]    amt_i,
    input logic [DW-1:0]    res_o,
    input logic             res_ok_o,
    input logic [1:0]       ca_o,
    input logic [2:0]       op_o,
    input logic             w32_o,
    input logic             sgn_o,
    input logic [TAG_W-1:0] tag_o
);
    localparam int HW = DW / 2;
    logic sign_bit;
    assign sign_bit = w32_i ? src_i[HW-1] : src_i[DW-1];

    always_comb begin
        a_r7_carry_pair: assert (ca_o[0] == ca_o[1])
            else $error("carry copies differ");
        a_r7_no_carry_other: assert (!(op_i != 3'd1 || !sgn_i) || ca_o == 2'b00)
            else $error("carry outside arithmetic right shift");
        a_r6_carry_needs_neg: assert (!ca_o[0] || (op_i == 3'd1 && sgn_i && sign_bit))
            else $error("carry without negative operand");
        a_r8_bad_op_quiet: assert (op_i <= 3'd2 || (!res_ok_o && res_o == '0 && ca_o == 2'b00))
            else $error("unsupported code not quiet");
        a_r8_good_op_valid: assert (op_i > 3'd2 || res_ok_o)
            else $error("supported code not valid");
        a_r2_upper_zero: assert (!(op_i == 3'd0 && w32_i) || res_o[DW-1:HW] == '0)
            else $error("word left shift upper half not zero");
        a_r1_big_amount: assert (!(op_i == 3'd0 && !w32_i && amt_i[6]) || res_o == '0)
            else $error("large left shift not zero");
        a_r3_big_amount: assert (!(op_i == 3'd1 && !w32_i && amt_i[6])
                                 || res_o == {DW{sgn_i & src_i[DW-1]}})
            else $error("large right shift not fill");
        a_r9_pass: assert (op_o == op_i && w32_o == w32_i && sgn_o == sgn_i && tag_o == tag_i)
            else $error("context changed");
    end
endmodule

bind shf_unit shf_unit_chk #(.DW(DW), .TAG_W(TAG_W)) u_chk (
    .op_i(op_i), .w32_i(w32_i), .sgn_i(sgn_i), .tag_i(tag_i), .src_i(src_i),
    .amt_i(amt_i), .res_o(res_o), .res_ok_o(res_ok_o), .ca_o(ca_o),
    .op_o(op_o), .w32_o(w32_o), .sgn_o(sgn_o), .tag_o(tag_o)
);

// File: tb/tb_shf_unit.sv
module tb_shf_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;
    localparam int TAG_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [2:0]       op_i = '0;
    logic             w32_i = 1'b0;
    logic             sgn_i = 1'b0;
    logic [TAG_W-1:0] tag_i = '0;
    logic [DW-1:0]    src_i = '0;
    logic [DW-1:0]    amt_i = '0;
    logic [DW-1:0]    res_o;
    logic             res_ok_o;
    logic [1:0]       ca_o;
    logic [2:0]       op_o;
    logic             w32_o;
    logic             sgn_o;
    logic [TAG_W-1:0] tag_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    shf_unit #(.DW(DW), .TAG_W(TAG_W)) dut (.*);

    function automatic void model(input logic [2:0] op, input logic w, input logic s,
                                  input logic [63:0] src, input logic [63:0] amt,
                                  output logic [63:0] res, output logic ok,
                                  output logic [1:0] ca);
        logic [63:0] ext;
        logic [63:0] t;
        logic signed [127:0] se;
        logic signed [127:0] r;
        logic [6:0] sh;
        logic c;
        res = '0; ok = 1'b1; c = 1'b0;
        case (op)
            3'd0: begin
                if (w) begin
                    t = src << amt[5:0];
                    res = {32'h0, t[31:0]};
                end else begin
                    res = src << amt[6:0];
                end
            end
            3'd1: begin
                if (w) begin
                    ext = s ? {{32{src[31]}}, src[31:0]} : {32'h0, src[31:0]};
                    sh = {1'b0, amt[5:0]};
                end else begin
                    ext = src;
                    sh = amt[6:0];
                end
                se = s ? {{64{ext[63]}}, ext} : {64'h0, ext};
                r = se >>> sh;
                res = r[63:0];
                c = s && ext[63] && ((r << sh) != se);
            end
            3'd2: begin
                ext = {{32{src[31]}}, src[31:0]};
                res = ext << amt[5:0];
            end
            default: ok = 1'b0;
        endcase
        ca = {c, c};
    endfunction

    task automatic check(input string rq, input bit good, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic run(input string rq, input logic [2:0] op, input logic w,
                       input logic s, input logic [63:0] src, input logic [63:0] amt);
        logic [63:0] e_res;
        logic e_ok;
        logic [1:0] e_ca;
        logic [TAG_W-1:0] tg;
        tg = TAG_W'($urandom);
        @(posedge clk);
        op_i = op; w32_i = w; sgn_i = s; src_i = src; amt_i = amt; tag_i = tg;
        @(negedge clk);
        model(op, w, s, src, amt, e_res, e_ok, e_ca);
        check(rq, (res_o == e_res) && (res_ok_o == e_ok) && (ca_o == e_ca),
              "res/ok/ca", {res_o, 61'h0, res_ok_o, ca_o}, {e_res, 61'h0, e_ok, e_ca});
        check("R9", {op_o, w32_o, sgn_o, tag_o} == {op, w, s, tg}, "context",
              128'({op_o, w32_o, sgn_o, tag_o}), 128'({op, w, s, tg}));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        // reset-time state: all inputs zero
        @(negedge clk);
        check("R8", res_o == '0 && res_ok_o && ca_o == 2'b00, "reset state",
              128'({res_o, res_ok_o, ca_o}), 128'({64'h0, 1'b1, 2'b00}));
        rst = 1'b0;

        // R1 doubleword left shifts
        run("R1", 3'd0, 0, 0, 64'h8000_0000_0000_0001, 64'd1);
        run("R1", 3'd0, 0, 0, 64'h0000_0000_0000_0003, 64'd63);
        run("R1", 3'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64);
        run("R1", 3'd0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd127);
        run("R1", 3'd0, 0, 0, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FF00_0000_0080);
        // R2 word left shifts
        run("R2", 3'd0, 1, 0, 64'hDEAD_BEEF_1234_5678, 64'd4);
        run("R2", 3'd0, 1, 0, 64'hFFFF_FFFF_0000_0001, 64'd31);
        run("R2", 3'd0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd32);
        run("R2", 3'd0, 1, 0, 64'h0000_0000_0000_00FF, 64'd67);
        // R3 doubleword right shifts
        run("R3", 3'd1, 0, 0, 64'hF000_0000_0000_00F0, 64'd4);
        run("R3", 3'd1, 0, 1, 64'hF000_0000_0000_00F0, 64'd4);
        run("R3", 3'd1, 0, 1, 64'h8000_0000_0000_0000, 64'd64);
        run("R3", 3'd1, 0, 0, 64'h8000_0000_0000_0000, 64'd100);
        run("R3", 3'd1, 0, 1, 64'h4000_0000_0000_0001, 64'd127);
        // R6 lost-bit boundary: ones exactly at and past the edge
        run("R6", 3'd1, 0, 1, 64'hFFFF_FFFF_FFFF_FF00, 64'd8);
        run("R6", 3'd1, 0, 1, 64'hFFFF_FFFF_FFFF_FF80, 64'd8);
        run("R6", 3'd1, 0, 1, 64'hFFFF_FFFF_FFFF_FF00, 64'd9);
        run("R6", 3'd1, 0, 1, 64'h8000_0000_0000_0000, 64'd63);
        run("R6", 3'd1, 0, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd8);
        run("R6", 3'd1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
        // R4 word right shifts (upper source bits must not matter)
        run("R4", 3'd1, 1, 1, 64'h1234_5678_8000_0001, 64'd1);
        run("R4", 3'd1, 1, 1, 64'h0000_0000_8000_0000, 64'd40);
        run("R4", 3'd1, 1, 0, 64'hFFFF_FFFF_8000_0000, 64'd40);
        run("R4", 3'd1, 1, 0, 64'hFFFF_FFFF_8000_0010, 64'd4);
        run("R4", 3'd1, 1, 1, 64'hFFFF_FFFF_7FFF_FFFF, 64'd32);
        run("R6", 3'd1, 1, 1, 64'h0000_0000_8000_0100, 64'd8);
        run("R6", 3'd1, 1, 1, 64'h0000_0000_8000_0100, 64'd9);
        // R5 sign-extend then shift
        run("R5", 3'd2, 0, 0, 64'h0000_0000_8000_0001, 64'd0);
        run("R5", 3'd2, 1, 1, 64'h0000_0000_8000_0001, 64'd4);
        run("R5", 3'd2, 0, 0, 64'hFFFF_FFFF_7FFF_FFFF, 64'd63);
        run("R5", 3'd2, 1, 0, 64'h0000_0000_FFFF_FFFF, 64'd64);
        // R7 carry zero on non-arithmetic shifts
        run("R7", 3'd1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5);
        run("R7", 3'd0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5);
        run("R7", 3'd2, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5);
        // R8 unsupported codes
        for (int c = 3; c < 8; c++)
            run("R8", 3'(c), 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] op;
            logic [63:0] src;
            logic [63:0] amt;
            string rq;
            op = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(3, 7))
                                             : 3'($urandom_range(0, 2));
            src = {$urandom, $urandom};
            case ($urandom_range(0, 3))
                0: src = src | 64'h8000_0000_8000_0000;
                1: src = src & ~((64'h1 << $urandom_range(0, 63)) - 64'h1);
                default: ;
            endcase
            case ($urandom_range(0, 2))
                0: amt = 64'($urandom_range(0, 70));
                1: amt = 64'({30, 31, 32, 33, 62, 63, 64, 65}[$urandom_range(0, 7) * 7 +: 7]);
                default: amt = {$urandom, $urandom};
            endcase
            case (op)
                3'd0: rq = "R1";
                3'd1: rq = "R6";
                3'd2: rq = "R5";
                default: rq = "R8";
            endcase
            run(rq, op, 1'($urandom), 1'($urandom), src, amt);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule